// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog

This block guards software liveness with a coarse down-counter that escalates instead of firing once. Software writes a configuration word that holds an operating mode, a 16-bit reload length and two freeze enables. It must then keep writing a separate poke strobe. A divider turns the input clock into one step every `PRESCALE` cycles, and a 24-bit count decrements on each step. On a reload the count takes the length as its upper 16 bits and ones as its lower 8 bits.

When the count runs out, the expiry stage advances and the count reloads. The first expiry raises a first interrupt and the second raises a second interrupt. The third asserts a reset request that holds until the watchdog is switched off. The mode caps how far the escalation may go. The whole state can be read back through one 64-bit word. Freeze inputs for debug and for a global halt stop all counting while their enable bits are set.

Top module: `tri_stage_wdog`

## Requirements
- R1: Readback word `cfg_rdata`: bits [1:0] mode, [3:2] expiry stage, [19:4] length, [43:20] live count, bit 44 debug-freeze enable, bit 45 global-freeze enable, all other bits zero. After reset the word is zero and all three outputs are low.
- R2: Mode 0 means stopped. A configuration write with mode 0 clears the stage, the count, both interrupts and the reset request. A poke while stopped changes nothing.
- R3: A write that moves the mode from 0 to non-zero, or a poke while running, loads the count with {length, 8'hFF} and clears the divider. The count then drops by one every `PRESCALE` cycles.
- R4: One stage lasts (length+1)·256·`PRESCALE` cycles from the load. On each expiry the stage field rises by one and the count reloads from the current length.
- R5: The first expiry sets `irq_first_o` and the second sets `irq_second_o`. The third sets `rst_req_o`, which stays high until a mode-0 write or a reset.
- R6: The stage never passes the mode. In mode 1 escalation stops at stage 1, in mode 2 at stage 2, and in mode 3 at stage 3. Once the cap is reached, the stage and the count hold.
- R7: A poke clears the stage to 0 and drops both interrupts. It leaves `rst_req_o` unchanged.
- R8: While bit 44 is set and `dbg_stop_i` is high, the divider and the count hold. With bit 44 clear, `dbg_stop_i` has no effect.
- R9: While bit 45 is set and `glb_stop_i` is high, the divider and the count hold. With bit 45 clear, `glb_stop_i` has no effect.
- R10: A configuration write with a non-zero mode while the watchdog is running keeps the count and the stage and clears the divider. The new length is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration write data (layout as in R1; stage and count bits ignored) |
| cfg_rdata | output | 64 | Live configuration and status word |
| poke_we | input | 1 | Poke strobe; restarts the current interval |
| dbg_stop_i | input | 1 | Debug halt indication |
| glb_stop_i | input | 1 | Global halt indication |
| irq_first_o | output | 1 | First-expiry interrupt level |
| irq_second_o | output | 1 | Second-expiry interrupt level |
| rst_req_o | output | 1 | Reset request after the third expiry |

## Verification
The hardest state to reach is a length change in the middle of a stage. The count must carry on from its current value under the old length, yet the reload that follows the expiry must use the new length. The bench starts a stage, waits a known number of divider periods, rewrites the length and then times both the remaining part of the stage and the full stage after it. Every mode is swept against two lengths with a divider of 4. This brings each run up to its cap and past it, and each freeze input is applied over a fixed window both with its enable set and with it clear.

// File: rtl/wdg3_pkg.sv
package wdg3_pkg;
  localparam int REG_W     = 64;
  localparam int MODE_W    = 2;
  localparam int STATE_W   = 2;
  localparam int MODE_LSB  = 0;
  localparam int STATE_LSB = 2;
  localparam int LEN_LSB   = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_RESET  = 2'd3
  } stage_e;
endpackage

// File: rtl/wdg3_prescale.sv
module wdg3_prescale #(
  parameter int PRESCALE = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic freeze,
  output logic tick_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = run && !freeze && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
    end else if (run && !freeze) begin
      pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
    end
  end

  // R8 and R9: a frozen divider keeps its phase
  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clr) |=> $stable(pre_q));

  assert_clr_zero_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/wdg3_downcnt.sv
module wdg3_downcnt #(
  parameter int LEN_W  = 16,
  parameter int FINE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    load,
  input  logic [LEN_W-1:0]        len_i,
  input  logic                    tick,
  input  logic                    enable,
  output logic [LEN_W+FINE_W-1:0] cnt_o,
  output logic                    expire_o
);
  localparam int CNT_W = LEN_W + FINE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload   = {len_i, {FINE_W{1'b1}}};
  assign expire_o = tick && enable && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= reload;
    end else if (tick && enable) begin
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - CNT_W'(1);
    end
  end

  assert_tick_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && enable && !clear && !load && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_expire_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !clear && !load)
      |=> (cnt_q == {$past(len_i), {FINE_W{1'b1}}}));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clear && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg3_stage.sv
module wdg3_stage
  import wdg3_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clear,
  input  logic   poke,
  input  logic   expire,
  output stage_e state_o,
  output logic   irq_first_o,
  output logic   irq_second_o,
  output logic   rst_req_o
);
  stage_e state_q;
  logic   irq1_q, irq2_q, rreq_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q <= ST_IDLE;
      irq1_q  <= 1'b0;
      irq2_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else if (poke) begin
      state_q <= ST_IDLE;
      irq1_q  <= 1'b0;
      irq2_q  <= 1'b0;
    end else if (expire) begin
      case (state_q)
        ST_IDLE:   begin state_q <= ST_FIRST;  irq1_q <= 1'b1; end
        ST_FIRST:  begin state_q <= ST_SECOND; irq2_q <= 1'b1; end
        ST_SECOND: begin state_q <= ST_RESET;  rreq_q <= 1'b1; end
        default:   state_q <= state_q;
      endcase
    end
  end

  assign state_o      = state_q;
  assign irq_first_o  = irq1_q;
  assign irq_second_o = irq2_q;
  assign rst_req_o    = rreq_q;

  assert_rst_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rreq_q && !clear) |=> rreq_q);

  assert_irq_order_R5: assert property (@(posedge clk) disable iff (rst)
    irq2_q |-> irq1_q);

  assert_poke_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (poke && !clear) |=> (state_q == ST_IDLE && !irq1_q && !irq2_q));
endmodule

// File: rtl/tri_stage_wdog.sv
module tri_stage_wdog
  import wdg3_pkg::*;
#(
  parameter int PRESCALE = 1024,
  parameter int LEN_W    = 16,
  parameter int FINE_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             poke_we,
  input  logic             dbg_stop_i,
  input  logic             glb_stop_i,
  output logic             irq_first_o,
  output logic             irq_second_o,
  output logic             rst_req_o
);
  localparam int CNT_W     = LEN_W + FINE_W;
  localparam int CNT_LSB   = LEN_LSB + LEN_W;
  localparam int DSTOP_BIT = CNT_LSB + CNT_W;
  localparam int GSTOP_BIT = DSTOP_BIT + 1;

  logic [MODE_W-1:0] mode_q;
  logic [LEN_W-1:0]  len_q;
  logic              dstop_q, gstop_q;

  logic [MODE_W-1:0] wr_mode;
  logic [LEN_W-1:0]  wr_len, len_use;
  logic              wr_off, wr_start, do_poke, running, freeze;
  logic              tick, expire, cnt_en;
  logic [CNT_W-1:0]  cnt;
  stage_e            state;

  assign wr_mode  = cfg_wdata[MODE_LSB +: MODE_W];
  assign wr_len   = cfg_wdata[LEN_LSB +: LEN_W];
  assign running  = (mode_q != '0);
  assign wr_off   = cfg_we && (wr_mode == '0);
  assign wr_start = cfg_we && (wr_mode != '0) && !running;
  assign do_poke  = poke_we && running && !cfg_we;
  assign len_use  = cfg_we ? wr_len : len_q;
  assign freeze   = (dstop_q && dbg_stop_i) || (gstop_q && glb_stop_i);
  assign cnt_en   = running && (state < stage_e'(mode_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      len_q   <= '0;
      dstop_q <= 1'b0;
      gstop_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= wr_mode;
      len_q   <= wr_len;
      dstop_q <= cfg_wdata[DSTOP_BIT];
      gstop_q <= cfg_wdata[GSTOP_BIT];
    end
  end

  wdg3_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (cfg_we || do_poke),
    .run    (running),
    .freeze (freeze),
    .tick_o (tick)
  );

  wdg3_downcnt #(.LEN_W(LEN_W), .FINE_W(FINE_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (wr_off),
    .load     (wr_start || do_poke),
    .len_i    (len_use),
    .tick     (tick),
    .enable   (cnt_en),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdg3_stage u_stage (
    .clk          (clk),
    .rst          (rst),
    .clear        (wr_off),
    .poke         (do_poke || wr_start),
    .expire       (expire),
    .state_o      (state),
    .irq_first_o  (irq_first_o),
    .irq_second_o (irq_second_o),
    .rst_req_o    (rst_req_o)
  );

  always_comb begin
    cfg_rdata                          = '0;
    cfg_rdata[MODE_LSB +: MODE_W]      = mode_q;
    cfg_rdata[STATE_LSB +: STATE_W]    = state;
    cfg_rdata[LEN_LSB +: LEN_W]        = len_q;
    cfg_rdata[CNT_LSB +: CNT_W]        = cnt;
    cfg_rdata[DSTOP_BIT]               = dstop_q;
    cfg_rdata[GSTOP_BIT]               = gstop_q;
  end

  assert_mode_cap_R6: assert property (@(posedge clk) disable iff (rst)
    (running && state == stage_e'(mode_q) && !cfg_we && !poke_we)
      |=> $stable(state));

  assert_off_clears_R2: assert property (@(posedge clk) disable iff (rst)
    wr_off |=> (state == ST_IDLE && cnt == '0 && !rst_req_o && !irq_first_o));

  assert_stopped_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!running && !cfg_we) |=> ($stable(cnt) && $stable(state)));
endmodule

// File: tb/test_tri_stage_wdog.sv
module test_tri_stage_wdog;
  localparam int P  = 4;
  localparam int T0 = 256 * P;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        poke_we = 1'b0;
  logic        dbg_stop_i = 1'b0;
  logic        glb_stop_i = 1'b0;
  logic        irq_first_o, irq_second_o, rst_req_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tri_stage_wdog #(.PRESCALE(P)) i_tri_stage_wdog (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .poke_we      (poke_we),
    .dbg_stop_i   (dbg_stop_i),
    .glb_stop_i   (glb_stop_i),
    .irq_first_o  (irq_first_o),
    .irq_second_o (irq_second_o),
    .rst_req_o    (rst_req_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int mode, input int len, input bit ds, input bit gs);
    cfg_wdata = (64'(mode) & 64'h3) | ((64'(len) & 64'hFFFF) << 4)
              | (64'(ds) << 44) | (64'(gs) << 45);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic poke();
    poke_we = 1'b1;
    @(negedge clk);
    poke_we = 1'b0;
  endtask

  function automatic int st();
    return int'(cfg_rdata[3:2]);
  endfunction

  function automatic int cnt();
    return int'(cfg_rdata[43:20]);
  endfunction

  task automatic chk_stage(input string req, input int s);
    chk(req, 64'(st()), 64'(s));
    chk(req, {61'd0, irq_first_o, irq_second_o, rst_req_o},
        {61'd0, s >= 1, s >= 2, s == 3});
  endtask

  task automatic run_freeze(input string req, input bit ds, input bit gs,
                            input bit dbg, input bit glb, input int shift);
    wr(1, 0, ds, gs);
    dbg_stop_i = dbg;
    glb_stop_i = glb;
    wait_n(100);
    dbg_stop_i = 1'b0;
    glb_stop_i = 1'b0;
    wait_n(T0 + shift - 1 - 100);
    chk(req, 64'(st()), 64'd0);
    wait_n(1);
    chk(req, 64'(st()), 64'd1);
    wr(0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 reset word", cfg_rdata, 64'd0);
    chk("R1 reset outputs", {61'd0, irq_first_o, irq_second_o, rst_req_o}, 64'd0);

    // R1: field layout on readback
    wr(1, 3, 1, 0);
    chk("R1 layout", cfg_rdata,
        64'h1 | (64'h3 << 4) | (64'h3FF << 20) | (64'h1 << 44));
    wr(0, 0, 0, 1);
    chk("R2 off clears", cfg_rdata, 64'h1 << 45);
    wr(0, 0, 0, 0);
    poke();
    chk("R2 poke while stopped", cfg_rdata, 64'd0);

    // R3: load value and decrement rate
    wr(3, 0, 0, 0);
    chk("R3 load", 64'(cnt()), 64'd255);
    wait_n(P - 1);
    chk("R3 before step", 64'(cnt()), 64'd255);
    wait_n(1);
    chk("R3 first step", 64'(cnt()), 64'd254);
    wait_n(4 * P);
    chk("R3 five steps", 64'(cnt()), 64'd250);
    wr(0, 0, 0, 0);

    // R4 R5 R6: sweep modes and lengths
    for (int m = 1; m <= 3; m++) begin
      for (int l = 0; l <= 1; l++) begin
        int t;
        int el;
        t  = (l + 1) * T0;
        el = 0;
        wr(m, l, 0, 0);
        for (int s = 1; s <= 3; s++) begin
          wait_n(s * t - 1 - el);
          chk_stage("R4 before expiry", (s - 1 < m) ? s - 1 : m);
          wait_n(1);
          el = s * t;
          chk_stage("R5 after expiry", (s < m) ? s : m);
          if (s <= m) chk("R4 reload", 64'(cnt()), 64'((l + 1) * 256 - 1));
        end
        wait_n(t);
        chk_stage("R6 capped", m);
        chk("R6 count held", 64'(cnt()), 64'((l + 1) * 256 - 1));
        wr(0, 0, 0, 0);
        chk("R2 disable", {61'd0, irq_first_o, irq_second_o, rst_req_o}, 64'd0);
      end
    end

    // R7: poke behaviour
    wr(3, 0, 0, 0);
    wait_n(T0 + 512);
    chk_stage("R7 pre-poke", 1);
    poke();
    chk_stage("R7 poke clears", 0);
    chk("R7 poke reload", 64'(cnt()), 64'd255);
    wait_n(T0 - 1);
    chk("R7 restart before", 64'(st()), 64'd0);
    wait_n(1);
    chk("R7 restart after", 64'(st()), 64'd1);
    wait_n(2 * T0);
    chk_stage("R5 reset stage", 3);
    poke();
    chk("R7 keeps reset", {61'd0, irq_first_o, irq_second_o, rst_req_o}, 64'b001);
    chk("R7 stage zero", 64'(st()), 64'd0);
    wr(0, 0, 0, 0);
    chk("R2 reset drop", cfg_rdata | 64'(rst_req_o), 64'd0);

    // R8 R9: freeze inputs
    run_freeze("R8 debug freeze", 1, 0, 1, 0, 100);
    run_freeze("R8 debug ignored", 0, 0, 1, 0, 0);
    run_freeze("R9 global freeze", 0, 1, 0, 1, 100);
    run_freeze("R9 global ignored", 0, 0, 0, 1, 0);

    // R10: length rewrite while running
    wr(3, 0, 0, 0);
    wait_n(500);
    chk("R10 count before", 64'(cnt()), 64'd130);
    wr(3, 1, 0, 0);
    chk("R10 count kept", 64'(cnt()), 64'd130);
    chk("R10 stage kept", 64'(st()), 64'd0);
    wait_n(4 * 131 - 1);
    chk("R10 stage before", 64'(st()), 64'd0);
    wait_n(1);
    chk("R10 stage one", 64'(st()), 64'd1);
    chk("R10 new reload", 64'(cnt()), 64'd511);
    wait_n(2 * T0 - 1);
    chk("R10 long stage before", 64'(st()), 64'd1);
    wait_n(1);
    chk("R10 long stage after", 64'(st()), 64'd2);
    wr(0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule